// File: doc/BRIEF.md
# Multicycle 24-bit Accumulator Processor Core

This block is a compact multicycle processor for a 24-bit accumulator machine. It holds an accumulator, an index register, a link register, a program counter and a condition code. It fetches three-byte instructions over a byte-wide synchronous memory port. Each instruction carries an 8-bit opcode, an index flag and a 15-bit address field. From these the core runs loads, stores, signed arithmetic, compare, conditional and unconditional jumps, subroutine call and return, and byte transfers to external devices.

Memory lives outside the core. The core drives an address and a write strobe, and read data must come back on the cycle after the address is presented. Every memory word is three bytes long and may start at any byte address. The device port gives a device number, a ready input and one-cycle read and write strobes. An undefined opcode stops the core and asserts `halt` until the next reset.

Top module: `acc24_core`

## Requirements
- R1: While `rst_n` is low and on release, the accumulator, index, link, program counter and condition code are zero. `halt`, `div_err`, `mem_wr`, `dev_rd` and `dev_wr` are low, and the first fetch reads address 0, then 1.
- R2: Read data on `mem_rdata` belongs to the address presented one cycle earlier. A write takes effect at the clock edge on which `mem_wr` is high. An instruction is three bytes taken big-endian from PC: opcode in bits [23:16], index flag in bit [15], address field in bits [14:0]. PC advances by 3 after each fetch.
- R3: The target address is the address field when the index flag is 0. When the flag is 1 it is the field plus the index register, modulo 2^15. A word occupies target, target+1 and target+2, wrapping modulo 2^15, with the lowest address holding bits [23:16].
- R4: 0x00 loads the accumulator, 0x04 loads the index register and 0x08 loads the link register from the word at the target. 0x0C, 0x10 and 0x14 store those same three registers to it.
- R5: 0x18 adds the word to the accumulator, 0x1C subtracts it, and 0x20 multiplies by it. Each result keeps its low 24 bits.
- R6: 0x24 divides the accumulator by the word as signed two's complement numbers, truncating toward zero, using 24 iteration cycles. A zero divisor leaves the accumulator unchanged and sets `div_err`, which stays high until reset.
- R7: 0x28 compares the accumulator with the word as signed numbers and sets the condition code (status bits [7:6]) to 00 for less, 01 for equal and 10 for greater. 0x38, 0x30 and 0x34 jump to the target only when the code is less, equal or greater respectively, and otherwise fall through. 0x3C always jumps.
- R8: 0x48 writes the address of the following instruction into the link register and jumps to the target. 0x4C loads PC from the link register.
- R9: 0xE0 places the low 8 bits of the target on `dev_sel` and sets the condition code to less when `dev_rdy` is high and to equal when it is low. It pulses neither strobe.
- R10: 0xD8 pulses `dev_rd` for one cycle and replaces accumulator bits [7:0] with `dev_rdata`, keeping bits [23:8]. 0xDC pulses `dev_wr` for one cycle with accumulator bits [7:0] on `dev_wdata`. Both present the low 8 bits of the target on `dev_sel`.
- R11: Any other opcode asserts `halt`. It then stays high, with no further memory write or device strobe, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 15 | Byte address to memory |
| mem_wr | output | 1 | Write strobe for the addressed byte |
| mem_wdata | output | 8 | Byte to be written |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| dev_sel | output | 8 | Device number for the I/O instructions |
| dev_rdy | input | 1 | Selected device is ready |
| dev_rd | output | 1 | One-cycle device read strobe |
| dev_wr | output | 1 | One-cycle device write strobe |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte returned by the device |
| halt | output | 1 | Undefined opcode reached, core stopped |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
Random arithmetic trials pair full-range operands with small signed divisors near zero. This separates sign handling, truncation toward zero and the zero-divisor path in the divider from plain modulo-2^24 add, subtract and multiply. Directed cases cover 0x7FFFFF+1, the most negative value divided by -1, and the three compare outcomes taken through each conditional jump. An index step that wraps the target past 0x7FFF reads a word split across the top and bottom of memory, which distinguishes correct wrapping and byte order from aliasing. Running the ready test with `dev_rdy` both high and low, and a nested call whose link register is later reloaded by hand, confirms that return goes through the link register and not a fixed address.

// File: rtl/acc24_core.sv
module acc24_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [14:0] mem_addr,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  dev_sel,
  input  logic        dev_rdy,
  output logic        dev_rd,
  output logic        dev_wr,
  output logic [7:0]  dev_wdata,
  input  logic [7:0]  dev_rdata,
  output logic        halt,
  output logic        div_err
);
  localparam int W  = 24;
  localparam int AW = 15;
  localparam int SW = $clog2(W);

  localparam logic [7:0] OP_LDA = 8'h00, OP_LDX = 8'h04, OP_LDL = 8'h08;
  localparam logic [7:0] OP_STA = 8'h0C, OP_STX = 8'h10, OP_STL = 8'h14;
  localparam logic [7:0] OP_ADD = 8'h18, OP_SUB = 8'h1C, OP_MUL = 8'h20;
  localparam logic [7:0] OP_DIV = 8'h24, OP_CMP = 8'h28;
  localparam logic [7:0] OP_JEQ = 8'h30, OP_JGT = 8'h34, OP_JLT = 8'h38, OP_J = 8'h3C;
  localparam logic [7:0] OP_JSUB = 8'h48, OP_RSUB = 8'h4C;
  localparam logic [7:0] OP_RD = 8'hD8, OP_WD = 8'hDC, OP_TD = 8'hE0;
  localparam logic [1:0] CC_LT = 2'b00, CC_EQ = 2'b01, CC_GT = 2'b10;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_LOAD, S_STORE, S_DIV, S_IO, S_HALT} st_t;

  st_t            st;
  logic [W-1:0]   ra, rx, rl, pc, ir, sdata, q, dvs;
  logic [W:0]     rem;
  logic [15:0]    buf16;
  logic [AW-1:0]  ta;
  logic [1:0]     cnt, cc_q;
  logic [SW-1:0]  dstep;
  logic           qneg;

  wire [7:0]    op    = ir[23:16];
  wire [AW-1:0] ta_c  = ir[AW-1:0] + (ir[AW] ? rx[AW-1:0] : '0);
  wire [W-1:0]  word  = {buf16, mem_rdata};
  wire [W-1:0]  prod  = ra * word;
  wire [W-1:0]  a_mag = ra[W-1] ? -ra : ra;
  wire [W-1:0]  w_mag = word[W-1] ? -word : word;
  wire [W:0]    r2    = {rem[W-2:0], q[W-1]};
  wire [W:0]    diff  = r2 - {1'b0, dvs};
  wire [W-1:0]  q_nx  = {q[W-2:0], ~diff[W]};

  assign mem_addr  = (st == S_FETCH) ? pc[AW-1:0] + AW'(cnt) : ta + AW'(cnt);
  assign mem_wr    = (st == S_STORE);
  assign mem_wdata = (cnt == 2'd0) ? sdata[23:16] : (cnt == 2'd1) ? sdata[15:8] : sdata[7:0];
  assign dev_sel   = ta[7:0];
  assign dev_rd    = (st == S_IO) && (op == OP_RD);
  assign dev_wr    = (st == S_IO) && (op == OP_WD);
  assign dev_wdata = ra[7:0];
  assign halt      = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH;
      ra <= '0; rx <= '0; rl <= '0; pc <= '0; ir <= '0; sdata <= '0;
      q <= '0; dvs <= '0; rem <= '0; buf16 <= '0; ta <= '0;
      cnt <= '0; cc_q <= '0; dstep <= '0; qneg <= 1'b0; div_err <= 1'b0;
    end else begin
      case (st)
        S_FETCH: begin
          if (cnt != 2'd0) ir <= {ir[15:0], mem_rdata};
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            pc <= pc + W'(3);
            st <= S_DEC;
          end
        end
        S_DEC: begin
          ta  <= ta_c;
          cnt <= '0;
          st  <= S_FETCH;
          case (op)
            OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_CMP: st <= S_LOAD;
            OP_STA: begin sdata <= ra; st <= S_STORE; end
            OP_STX: begin sdata <= rx; st <= S_STORE; end
            OP_STL: begin sdata <= rl; st <= S_STORE; end
            OP_J:   pc <= W'(ta_c);
            OP_JEQ: if (cc_q == CC_EQ) pc <= W'(ta_c);
            OP_JGT: if (cc_q == CC_GT) pc <= W'(ta_c);
            OP_JLT: if (cc_q == CC_LT) pc <= W'(ta_c);
            OP_JSUB: begin rl <= pc; pc <= W'(ta_c); end
            OP_RSUB: pc <= rl;
            OP_TD, OP_RD, OP_WD: st <= S_IO;
            default: st <= S_HALT;
          endcase
        end
        S_LOAD: begin
          if (cnt != 2'd0) buf16 <= {buf16[7:0], mem_rdata};
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            st <= S_FETCH;
            case (op)
              OP_LDA: ra <= word;
              OP_LDX: rx <= word;
              OP_LDL: rl <= word;
              OP_ADD: ra <= ra + word;
              OP_SUB: ra <= ra - word;
              OP_MUL: ra <= prod;
              OP_CMP: cc_q <= ($signed(ra) < $signed(word)) ? CC_LT :
                              (ra == word) ? CC_EQ : CC_GT;
              OP_DIV: begin
                if (word == '0) div_err <= 1'b1;
                else begin
                  q     <= a_mag;
                  dvs   <= w_mag;
                  rem   <= '0;
                  dstep <= '0;
                  qneg  <= ra[W-1] ^ word[W-1];
                  st    <= S_DIV;
                end
              end
              default: ;
            endcase
          end
        end
        S_STORE: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd2) begin
            cnt <= '0;
            st  <= S_FETCH;
          end
        end
        S_DIV: begin
          rem   <= diff[W] ? r2 : diff;
          q     <= q_nx;
          dstep <= dstep + 1'b1;
          if (dstep == SW'(W - 1)) begin
            ra <= qneg ? -q_nx : q_nx;
            st <= S_FETCH;
          end
        end
        S_IO: begin
          if (op == OP_TD) cc_q <= dev_rdy ? CC_LT : CC_EQ;
          if (op == OP_RD) ra[7:0] <= dev_rdata;
          st <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && cnt == 2'd3) |=> (pc == $past(pc) + W'(3)));

  a_r3_store_bytes_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cnt != 2'd0) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r6_zero_divisor_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && cnt == 2'd3 && op == OP_DIV && word == '0) |=> (ra == $past(ra) && div_err));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);

  a_r7_cc_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cc_q != 2'b11);

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, dev_rd, dev_wr}));

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && !mem_wr && !dev_rd && !dev_wr));
endmodule

// File: tb/acc24_core_tb_top.sv
`timescale 1ns/1ps
module acc24_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [14:0] mem_addr;
  logic mem_wr, dev_rd, dev_wr, halt, div_err, dev_rdy;
  logic [7:0] mem_wdata, mem_rdata, dev_sel, dev_wdata;
  logic [7:0] dev_rdata = 8'h5A;
  logic [7:0] mem [0:4095];
  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] rsel, wsel, wdat;

  always #2.5 clk = ~clk;

  acc24_core dut_i (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_sel(dev_sel), .dev_rdy(dev_rdy),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .halt(halt), .div_err(div_err));

  function automatic int mi(input logic [14:0] a);
    return int'({a[14], a[10:0]});
  endfunction

  always @(posedge clk) begin
    if (mem_wr) mem[mi(mem_addr)] <= mem_wdata;
    mem_rdata <= mem[mi(mem_addr)];
    if (dev_rd) begin rd_cnt <= rd_cnt + 1; rsel <= dev_sel; end
    if (dev_wr) begin wr_cnt <= wr_cnt + 1; wsel <= dev_sel; wdat <= dev_wdata; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup();
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
  endtask

  task automatic ins(input int a, input logic [7:0] op, input logic x, input int f);
    logic [14:0] aa, fa;
    aa = a[14:0]; fa = f[14:0];
    mem[mi(aa)] <= op;
    mem[mi(aa + 15'd1)] <= {x, fa[14:8]};
    mem[mi(aa + 15'd2)] <= fa[7:0];
  endtask

  task automatic putw(input int a, input logic [23:0] w);
    logic [14:0] aa;
    aa = a[14:0];
    mem[mi(aa)] <= w[23:16];
    mem[mi(aa + 15'd1)] <= w[15:8];
    mem[mi(aa + 15'd2)] <= w[7:0];
  endtask

  function automatic logic [23:0] rdw(input int a);
    logic [14:0] aa;
    aa = a[14:0];
    return {mem[mi(aa)], mem[mi(aa + 15'd1)], mem[mi(aa + 15'd2)]};
  endfunction

  task automatic run();
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halt && n < 600) begin @(negedge clk); n++; end
    if (!halt) chk("R11 program halts", 32'd0, 32'd1);
  endtask

  function automatic logic [23:0] exp_ar(input logic [7:0] op, input logic [23:0] a,
                                         input logic [23:0] b);
    logic [47:0] p;
    int sa, sb, qq;
    case (op)
      8'h18: return a + b;
      8'h1C: return a - b;
      8'h20: begin p = a * b; return p[23:0]; end
      default: begin
        if (b == 24'd0) return a;
        sa = $signed(a); sb = $signed(b); qq = sa / sb;
        return qq[23:0];
      end
    endcase
  endfunction

  function automatic logic [23:0] exp_cmp(input logic [23:0] a, input logic [23:0] b);
    if ($signed(a) < $signed(b)) return 24'd1;
    if (a == b) return 24'd2;
    return 24'd3;
  endfunction

  task automatic arith(input logic [7:0] op, input logic [23:0] a, input logic [23:0] b);
    setup();
    ins(0, 8'h00, 0, 'h100); ins(3, op, 0, 'h103); ins(6, 8'h0C, 0, 'h106); ins(9, 8'hFF, 0, 0);
    putw('h100, a); putw('h103, b);
    run();
    case (op)
      8'h18, 8'h1C, 8'h20: chk("R5 add/sub/mul result", rdw('h106), exp_ar(op, a, b));
      default: begin
        chk("R6 divide result", rdw('h106), exp_ar(op, a, b));
        chk("R6 div_err flag", div_err, (b == 24'd0));
      end
    endcase
  endtask

  task automatic compare(input logic [23:0] a, input logic [23:0] b);
    setup();
    ins('h00, 8'h00, 0, 'h100); ins('h03, 8'h28, 0, 'h103);
    ins('h06, 8'h38, 0, 'h015); ins('h09, 8'h34, 0, 'h01B); ins('h0C, 8'h30, 0, 'h021);
    ins('h0F, 8'hFF, 0, 0);
    ins('h15, 8'h00, 0, 'h10C); ins('h18, 8'h3C, 0, 'h024);
    ins('h1B, 8'h00, 0, 'h112); ins('h1E, 8'h3C, 0, 'h024);
    ins('h21, 8'h00, 0, 'h10F);
    ins('h24, 8'h0C, 0, 'h106); ins('h27, 8'hFF, 0, 0);
    putw('h100, a); putw('h103, b);
    putw('h10C, 24'd1); putw('h10F, 24'd2); putw('h112, 24'd3);
    run();
    chk("R7 compare and branch path", rdw('h106), exp_cmp(a, b));
  endtask

  initial begin
    int r0, w0;
    logic [7:0] ops [5];
    ops = '{8'h18, 8'h1C, 8'h20, 8'h24, 8'h28};
    void'($urandom(32'd20240611));
    dev_rdy = 1'b0;

    setup();
    ins(0, 8'hFF, 0, 0);
    repeat (2) @(negedge clk);
    chk("R1 halt low in reset", halt, 0);
    chk("R1 div_err low in reset", div_err, 0);
    chk("R1 no strobes in reset", {mem_wr, dev_rd, dev_wr}, 0);
    chk("R1 first fetch address", mem_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 second fetch byte address", mem_addr, 1);

    arith(8'h18, 24'h7FFFFF, 24'h000001);
    arith(8'h1C, 24'h000000, 24'h000001);
    arith(8'h20, 24'h123456, 24'h00ABCD);
    arith(8'h24, -24'sd7, 24'd2);
    arith(8'h24, 24'd7, -24'sd2);
    arith(8'h24, 24'h800000, 24'hFFFFFF);
    arith(8'h24, 24'h0ABCDE, 24'd0);
    compare(24'd5, 24'd5);
    compare(24'hFFFFFF, 24'd1);
    compare(24'd1, 24'hFFFFFF);

    for (int t = 0; t < 60; t++) begin
      logic [7:0] op;
      logic [23:0] a, b;
      int sb;
      op = ops[$urandom % 5];
      a = $urandom;
      b = $urandom;
      if ($urandom % 3 == 0) begin sb = int'($urandom % 7) - 3; b = sb[23:0]; end
      if (op == 8'h28) compare(a, b); else arith(op, a, b);
    end

    setup();
    ins('h00, 8'h04, 0, 'h100); ins('h03, 8'h00, 1, 'h100); ins('h06, 8'h0C, 1, 'h106);
    ins('h09, 8'h10, 0, 'h109); ins('h0C, 8'h00, 1, 'h7FDE); ins('h0F, 8'h0C, 0, 'h10C);
    ins('h12, 8'hFF, 0, 0);
    putw('h100, 24'h000020); putw('h120, 24'h13579B);
    mem[mi(15'h7FFE)] <= 8'hC3; mem[mi(15'h7FFF)] <= 8'h21;
    run();
    chk("R3 indexed store target", rdw('h126), 24'h13579B);
    chk("R3 unindexed address untouched", rdw('h106), 24'h0);
    chk("R4 STX stores index", rdw('h109), 24'h000020);
    chk("R3 word wraps at 0x7FFF big-endian", rdw('h10C), 24'hC32104);

    setup();
    ins('h00, 8'h00, 0, 'h100); ins('h03, 8'h48, 0, 'h030);
    ins('h06, 8'h14, 0, 'h106); ins('h09, 8'h08, 0, 'h10C); ins('h0C, 8'h4C, 0, 0);
    ins('h0F, 8'hFF, 0, 0);
    ins('h30, 8'h14, 0, 'h109); ins('h33, 8'h4C, 0, 0);
    ins('h40, 8'h0C, 0, 'h10F); ins('h43, 8'hFF, 0, 0);
    putw('h100, 24'h0ABCDE); putw('h10C, 24'h000040);
    run();
    chk("R8 JSUB link inside subroutine", rdw('h109), 24'd6);
    chk("R8 RSUB returned to caller", rdw('h106), 24'd6);
    chk("R8 RSUB follows loaded link", rdw('h10F), 24'h0ABCDE);

    for (int rdy = 0; rdy < 2; rdy++) begin
      setup();
      dev_rdy = rdy[0];
      ins('h00, 8'hE0, 0, 'h042); ins('h03, 8'h38, 0, 'h00F); ins('h06, 8'h00, 0, 'h10F);
      ins('h09, 8'h0C, 0, 'h106); ins('h0C, 8'hFF, 0, 0);
      ins('h0F, 8'h00, 0, 'h10C); ins('h12, 8'h0C, 0, 'h106); ins('h15, 8'hFF, 0, 0);
      putw('h10C, 24'd1); putw('h10F, 24'd2);
      r0 = rd_cnt; w0 = wr_cnt;
      run();
      chk("R9 TD ready maps to less", rdw('h106), rdy ? 24'd1 : 24'd2);
      chk("R9 TD pulses no strobe", (rd_cnt - r0) + (wr_cnt - w0), 0);
    end

    setup();
    ins('h00, 8'h00, 0, 'h100); ins('h03, 8'hD8, 0, 'h042); ins('h06, 8'h0C, 0, 'h106);
    ins('h09, 8'hDC, 0, 'h043); ins('h0C, 8'hFF, 0, 0);
    putw('h100, 24'h123456);
    r0 = rd_cnt; w0 = wr_cnt;
    run();
    chk("R10 RD keeps upper A bits", rdw('h106), 24'h12345A);
    chk("R10 one read strobe", rd_cnt - r0, 1);
    chk("R10 read device number", rsel, 8'h42);
    chk("R10 one write strobe", wr_cnt - w0, 1);
    chk("R10 write device and data", {wsel, wdat}, {8'h43, 8'h5A});

    setup();
    ins('h00, 8'h0C, 0, 'h106); ins('h03, 8'h44, 0, 0); ins('h06, 8'h0C, 0, 'h109);
    putw('h106, 24'h111111); putw('h109, 24'h222222);
    run();
    begin
      int wr_seen;
      wr_seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (mem_wr || !halt) wr_seen++;
      end
      chk("R11 halt held with no writes", wr_seen, 0);
    end
    chk("R4 STA before undefined opcode", rdw('h106), 24'h0);
    chk("R11 nothing executes after halt", rdw('h109), 24'h222222);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule